// File: doc/BRIEF.md
# 16-bit ModR/M Effective Offset Generator

This block turns a ModR/M byte from a 16-bit addressing form into an effective offset. It works out the offset from the base and index registers bx, bp, si and di and from the displacement bytes that follow the ModR/M byte. It also reports how many displacement bytes the instruction uses, so the fetch pointer can be advanced. It picks the segment code as well, defaulting to the stack segment for bp-based forms when no override prefix is present. The caller presents a two-byte window of the bytes that follow the ModR/M byte. Segment base translation and limit checks belong to a later stage.

The outputs are registered. A set of inputs appears at the outputs one clock later, and a new set of inputs may be presented on every cycle.

Top module: `amg16_ea`

## Requirements
- R1: When mod is 0 and r/m is not 6, offset_o is the register sum for r/m, taken modulo 2^16: 0 = bx+si, 1 = bx+di, 2 = bp+si, 3 = bp+di, 4 = si, 5 = di, 6 = bp, 7 = bx. disp_len_o is 0 in this case.
- R2: When mod is 0 and r/m is 6, offset_o equals the direct displacement disp_i and no register is added. disp_i[7:0] is the first byte, so the word is little-endian. disp_len_o is 2.
- R3: When mod is 1, offset_o is the r/m register sum plus disp_i[7:0], sign-extended to 16 bits. disp_len_o is 1.
- R4: When mod is 2, offset_o is the r/m register sum plus the full 16-bit disp_i. disp_len_o is 2.
- R5: All offset arithmetic wraps modulo 2^16. For example, bx=FFFF, si=0002 and mod 0 give 0001.
- R6: When mod is 3 (modrm_i[7:6]=11), invalid_o is 1, offset_o is 0, disp_len_o is 0, and seg_o returns seg_ovr_i unchanged. In every other case invalid_o is 0.
- R7: Segment codes use three bits: 0 = default data segment, 1 = es, 2 = cs, 3 = ss, 4 = ds, 5 = fs, 6 = gs. A nonzero seg_ovr_i is returned unchanged on seg_o.
- R8: When seg_ovr_i is 0, the mode is valid, r/m is 2, 3 or 6, and the form is not the direct case of R2, seg_o is 3 (ss). With seg_ovr_i at 0 in every other case, seg_o is 0.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge. While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| modrm_i | input | 8 | ModR/M byte: mod [7:6], reg [5:3], r/m [2:0] |
| disp_i | input | 16 | Displacement window; [7:0] is the first byte after the ModR/M byte |
| bx_i | input | 16 | bx register value |
| bp_i | input | 16 | bp register value |
| si_i | input | 16 | si register value |
| di_i | input | 16 | di register value |
| seg_ovr_i | input | 3 | Segment override code, 0 when there is no prefix |
| offset_o | output | 16 | Effective offset |
| disp_len_o | output | 2 | Displacement bytes consumed (0, 1 or 2) |
| seg_o | output | 3 | Chosen segment code |
| invalid_o | output | 1 | The mod field selects register mode |

## Verification
The only state is the output register, so a wrong internal value shows up at the ports on the very next cycle as a bad offset, length or segment for the inputs that were just presented. A mistake in the decode would pair the wrong registers, take the wrong sign or width of displacement, or miss the bp-to-stack switch. It is found by comparing every cycle against a reference model, using random and directed register values near the wrap boundary. The direct r/m 6 case needs special attention, because it looks like a bp form in the encoding but must leave the default segment alone.

// File: rtl/amg_pkg.sv
package amg_pkg;
  typedef enum logic [2:0] {
    SEG_DFLT = 3'd0,
    SEG_ES   = 3'd1,
    SEG_CS   = 3'd2,
    SEG_SS   = 3'd3,
    SEG_DS   = 3'd4,
    SEG_FS   = 3'd5,
    SEG_GS   = 3'd6,
    SEG_RSVD = 3'd7
  } seg_code_e;

  localparam logic [1:0] MOD_NODISP = 2'd0;
  localparam logic [1:0] MOD_DISP8  = 2'd1;
  localparam logic [1:0] MOD_DISP16 = 2'd2;
  localparam logic [1:0] MOD_REG    = 2'd3;
  localparam logic [2:0] RM_DIRECT  = 3'd6;
endpackage

// File: rtl/amg_disp_dec.sv
module amg_disp_dec
  import amg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]   mod_i,
  input  logic [2:0]   rm_i,
  input  logic [W-1:0] disp_i,
  output logic [W-1:0] disp_val_o,
  output logic [1:0]   disp_len_o,
  output logic         direct_o,
  output logic         invalid_o
);
  always_comb begin
    disp_val_o = '0;
    disp_len_o = 2'd0;
    direct_o   = 1'b0;
    invalid_o  = 1'b0;
    unique case (mod_i)
      MOD_NODISP: if (rm_i == RM_DIRECT) begin
        direct_o   = 1'b1;
        disp_val_o = disp_i;
        disp_len_o = 2'd2;
      end
      MOD_DISP8: begin
        disp_val_o = {{(W-8){disp_i[7]}}, disp_i[7:0]};
        disp_len_o = 2'd1;
      end
      MOD_DISP16: begin
        disp_val_o = disp_i;
        disp_len_o = 2'd2;
      end
      default: invalid_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/amg_pair_sum.sv
module amg_pair_sum #(
  parameter int W = 16
) (
  input  logic [2:0]   rm_i,
  input  logic [W-1:0] bx_i,
  input  logic [W-1:0] bp_i,
  input  logic [W-1:0] si_i,
  input  logic [W-1:0] di_i,
  output logic [W-1:0] sum_o,
  output logic         bp_form_o
);
  logic [W-1:0] base_v, index_v;

  // rm[2]=0: pair forms, base by rm[1], index by rm[0]; rm[2]=1: single register
  always_comb begin
    if (!rm_i[2]) begin
      base_v  = rm_i[1] ? bp_i : bx_i;
      index_v = rm_i[0] ? di_i : si_i;
    end else begin
      index_v = '0;
      unique case (rm_i[1:0])
        2'd0:    base_v = si_i;
        2'd1:    base_v = di_i;
        2'd2:    base_v = bp_i;
        default: base_v = bx_i;
      endcase
    end
  end

  assign sum_o     = base_v + index_v;
  assign bp_form_o = (rm_i == 3'd2) || (rm_i == 3'd3) || (rm_i == 3'd6);
endmodule

// File: rtl/amg_seg_pick.sv
module amg_seg_pick
  import amg_pkg::*;
(
  input  logic [2:0] ovr_i,
  input  logic       bp_form_i,
  input  logic       direct_i,
  input  logic       invalid_i,
  output logic [2:0] seg_o
);
  always_comb begin
    if (ovr_i != SEG_DFLT)
      seg_o = ovr_i;
    else if (bp_form_i && !direct_i && !invalid_i)
      seg_o = SEG_SS;
    else
      seg_o = SEG_DFLT;
  end
endmodule

// File: rtl/amg16_ea.sv
module amg16_ea
  import amg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [7:0]   modrm_i,
  input  logic [W-1:0] disp_i,
  input  logic [W-1:0] bx_i,
  input  logic [W-1:0] bp_i,
  input  logic [W-1:0] si_i,
  input  logic [W-1:0] di_i,
  input  logic [2:0]   seg_ovr_i,
  output logic [W-1:0] offset_o,
  output logic [1:0]   disp_len_o,
  output logic [2:0]   seg_o,
  output logic         invalid_o
);
  logic [1:0]   mod_w;
  logic [2:0]   rm_w;
  logic [W-1:0] disp_val, pair_sum, offset_d;
  logic [1:0]   len_d;
  logic [2:0]   seg_d;
  logic         direct, invalid_d, bp_form;

  assign mod_w = modrm_i[7:6];
  assign rm_w  = modrm_i[2:0];

  amg_disp_dec #(.W(W)) u_disp (
    .mod_i(mod_w), .rm_i(rm_w), .disp_i(disp_i),
    .disp_val_o(disp_val), .disp_len_o(len_d),
    .direct_o(direct), .invalid_o(invalid_d)
  );

  amg_pair_sum #(.W(W)) u_pair (
    .rm_i(rm_w), .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
    .sum_o(pair_sum), .bp_form_o(bp_form)
  );

  amg_seg_pick u_seg (
    .ovr_i(seg_ovr_i), .bp_form_i(bp_form), .direct_i(direct),
    .invalid_i(invalid_d), .seg_o(seg_d)
  );

  always_comb begin
    if (invalid_d)   offset_d = '0;
    else if (direct) offset_d = disp_val;
    else             offset_d = pair_sum + disp_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_o   <= '0;
      disp_len_o <= 2'd0;
      seg_o      <= SEG_DFLT;
      invalid_o  <= 1'b0;
    end else begin
      offset_o   <= offset_d;
      disp_len_o <= len_d;
      seg_o      <= seg_d;
      invalid_o  <= invalid_d;
    end
  end

  // primed: at least one clock edge since reset, so $past is meaningful
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  assert_len_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_len_o != 2'd3);

  assert_invalid_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (offset_o == '0 && disp_len_o == 2'd0));

  assert_disp8_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(modrm_i[7:6]) == MOD_DISP8) |-> (disp_len_o == 2'd1 && !invalid_o));

  assert_direct_offset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(modrm_i[7:6]) == MOD_NODISP && $past(modrm_i[2:0]) == RM_DIRECT)
      |-> (offset_o == $past(disp_i) && disp_len_o == 2'd2));

  assert_ovr_passes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(seg_ovr_i) != SEG_DFLT) |-> (seg_o == $past(seg_ovr_i)));

  assert_seg_ss_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(seg_ovr_i) == SEG_DFLT) |-> (seg_o == SEG_DFLT || seg_o == SEG_SS));
endmodule

// File: tb/tb_amg16_ea.sv
module tb_amg16_ea;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  modrm_i = '0;
  logic [15:0] disp_i = '0, bx_i = '0, bp_i = '0, si_i = '0, di_i = '0;
  logic [2:0]  seg_ovr_i = '0;
  logic [15:0] offset_o;
  logic [1:0]  disp_len_o;
  logic [2:0]  seg_o;
  logic        invalid_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  amg16_ea dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pair(input logic [2:0] rm);
    case (rm)
      3'd0: return bx_i + si_i;
      3'd1: return bx_i + di_i;
      3'd2: return bp_i + si_i;
      3'd3: return bp_i + di_i;
      3'd4: return si_i;
      3'd5: return di_i;
      3'd6: return bp_i;
      default: return bx_i;
    endcase
  endfunction

  task automatic apply(input logic [7:0] m, input logic [15:0] d, input logic [15:0] b,
                       input logic [15:0] p, input logic [15:0] s, input logic [15:0] i,
                       input logic [2:0] o);
    logic [1:0] md; logic [2:0] rm;
    logic [15:0] e_off; int e_len; int e_seg; int e_inv; string tag;
    @(negedge clk_i);
    modrm_i = m; disp_i = d; bx_i = b; bp_i = p; si_i = s; di_i = i; seg_ovr_i = o;
    md = m[7:6]; rm = m[2:0]; e_inv = 0;
    case (md)
      2'd0: if (rm == 3'd6) begin e_off = d; e_len = 2; tag = "R2"; end
            else begin e_off = pair(rm); e_len = 0; tag = "R1"; end
      2'd1: begin e_off = pair(rm) + {{8{d[7]}}, d[7:0]}; e_len = 1; tag = "R3"; end
      2'd2: begin e_off = pair(rm) + d; e_len = 2; tag = "R4"; end
      default: begin e_off = 16'd0; e_len = 0; e_inv = 1; tag = "R6"; end
    endcase
    if (o != 3'd0) e_seg = o;
    else if (e_inv == 0 && !(md == 2'd0 && rm == 3'd6) && (rm == 3'd2 || rm == 3'd3 || rm == 3'd6))
      e_seg = 3;
    else e_seg = 0;
    @(negedge clk_i);
    chk({tag, " offset"}, offset_o, e_off);
    chk({tag, " len"}, disp_len_o, e_len);
    chk((o != 0) ? "R7 seg" : "R8 seg", seg_o, e_seg);
    chk("R6 invalid", invalid_o, e_inv);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240517);
    // R9: outputs held at zero during reset despite active inputs
    modrm_i = 8'h86; disp_i = 16'h1234; bx_i = 16'h1111; seg_ovr_i = 3'd5;
    repeat (3) @(negedge clk_i);
    chk("R9 reset offset", offset_o, 0);
    chk("R9 reset len", disp_len_o, 0);
    chk("R9 reset seg", seg_o, 0);
    chk("R9 reset invalid", invalid_o, 0);
    rst_ni = 1'b1;
    // R1 every r/m in mod 0
    for (int r = 0; r < 8; r++)
      apply({2'b00, 3'b010, 3'(r)}, 16'hBEEF, 16'h0100, 16'h0200, 16'h0030, 16'h0004, 3'd0);
    // R2 direct: little-endian word, default segment stays, ignores bp
    apply(8'h06, 16'h3412, 16'h1, 16'hFFFF, 16'h1, 16'h1, 3'd0);
    // R3 negative and positive disp8
    apply(8'h42, 16'h00F0, 16'h0, 16'h0010, 16'h0005, 16'h0, 3'd0);
    apply(8'h47, 16'hFF7F, 16'h0100, 16'h0, 16'h0, 16'h0, 3'd0);
    // R4 disp16
    apply(8'h86, 16'h8000, 16'h0, 16'h1000, 16'h0, 16'h0, 3'd0);
    // R5 wrap
    apply(8'h00, 16'h0, 16'hFFFF, 16'h0, 16'h0002, 16'h0, 3'd0);
    apply(8'h83, 16'hFFFF, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 3'd0);
    // R6 register mode
    apply(8'hC6, 16'h1234, 16'h1, 16'h2, 16'h3, 16'h4, 3'd0);
    apply(8'hC2, 16'h1234, 16'h1, 16'h2, 16'h3, 16'h4, 3'd4);
    // R7 override beats bp default; R8 direct with override
    apply(8'h46, 16'h0002, 16'h0, 16'h0100, 16'h0, 16'h0, 3'd4);
    apply(8'h06, 16'h0002, 16'h0, 16'h0100, 16'h0, 16'h0, 3'd1);
    // random mix
    for (int k = 0; k < 400; k++)
      apply(8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
            16'($urandom), 16'($urandom), ($urandom % 2) ? 3'd0 : 3'($urandom));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule